// File: doc/BRIEF.md
# Indirect Byte Store Port with Lockable Windows

This block holds a byte-addressed store and offers two ways into it. The first is an indirect port: a host loads a 16-bit address through two byte offsets (low byte, then high byte, in any order) and then moves data through a third offset. Every data write through the port stores one byte and then returns the address latch to zero. A data read returns the byte at the latched address, and the address stays where it is.

The second way is a direct path. It takes a full address, a size code and up to 32 bits of data. It breaks 16-bit and 32-bit transfers into single-byte steps, one per clock. The most significant byte goes to the lowest address.

Two lock bits guard two fixed 16-byte windows. Each lock bit is flipped by its own toggle input. While a window is locked, its bytes cannot be changed and they read as 0xFF on both paths. Bytes at or above the store size behave the same way. Reset clears the lock bits and the address latch but leaves the stored bytes alone.

Top module: `nvp_port_top`

## Requirements
- R1: A port write at offset 0 replaces bits 7:0 of the address latch. A port write at offset 1 replaces bits 15:8. The other byte of the latch is kept in both cases.
- R2: A port write at offset 3 stores `pb_wdata` at the latched address. In the same clock the address latch becomes zero.
- R3: A port read at offset 3 loads `pb_rdata` with the byte at the latched address, and the value shows one clock later. A read at offset 0, 1 or 2 loads 0xFF. `pb_rdata` holds its value between reads.
- R4: A pulse on `lock_tgl[0]` inverts lock bit 0, and a pulse on `lock_tgl[1]` inverts lock bit 1. Each takes effect at the clock edge where it is sampled.
- R5: While lock bit 0 is set, bytes 0x20 to 0x2F ignore writes from either path and read as 0xFF on either path.
- R6: While lock bit 1 is set, bytes 0x30 to 0x3F are protected in the same way.
- R7: Addresses at or above `MEM_BYTES` (default 1024) ignore writes and read as 0xFF.
- R8: `dir_size` selects the transfer: 0 is one byte, 1 is two bytes, 2 or 3 is four bytes. Byte k of an n-byte transfer uses address `dir_addr`+k and data bits [8(n-1-k)+7 : 8(n-1-k)]. A read result is right-aligned in `dir_rdata` and zero-extended.
- R9: An n-byte direct transfer keeps `dir_busy` high for exactly n clocks. `dir_done` pulses for one clock after the last byte. A `dir_req` that arrives while busy is ignored.
- R10: Reset clears both lock bits and the address latch, sets `pb_rdata` to 0xFF, and leaves the stored bytes unchanged.
- R11: If a direct write byte and a port data write fall in the same clock, the direct byte is stored and the port byte is dropped. The address latch is still cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pb_off | input | 2 | Port offset select |
| pb_wr | input | 1 | Port write strobe |
| pb_rd | input | 1 | Port read strobe |
| pb_wdata | input | 8 | Port write data |
| pb_rdata | output | 8 | Registered port read data |
| dir_req | input | 1 | Direct transfer request |
| dir_we | input | 1 | Direct transfer is a write |
| dir_size | input | 2 | Direct transfer size code |
| dir_addr | input | AW (16) | Direct start address |
| dir_wdata | input | 32 | Direct write data, right-aligned |
| dir_rdata | output | 32 | Direct read result |
| dir_busy | output | 1 | Direct transfer in progress |
| dir_done | output | 1 | One-clock completion pulse |
| lock_tgl | input | 2 | Lock toggle requests, one per window |

## Verification
The port is exercised in three ways:
- A fill and readback with address-dependent data, which separates the low address byte from the high address byte.
- Back-to-back data writes without reloading the address, which shows whether the latch really returns to zero.
- Reads at the non-data offsets.

Lock windows are tried locked and unlocked, from the port and with a 4-byte direct transfer that straddles the boundary between the two windows. A transfer whose bytes come back as partly 0xFF and partly real shows per-byte gating and big-endian ordering in a single result.

A direct write with a colliding port write and an overlapping request, followed by a reset in the middle of a run, separates write priority, request dropping and what reset is allowed to clear.

// File: rtl/nvp_pkg.sv
// Shared constants and types for the indirect byte store port.
// Assumes lock windows are 16 bytes long and aligned to 16 bytes.
package nvp_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORD2 = 2'd3
    } dsize_e;

    localparam logic [1:0] OFF_ALO  = 2'd0;
    localparam logic [1:0] OFF_AHI  = 2'd1;
    localparam logic [1:0] OFF_DATA = 2'd3;

    localparam int WIN_COUNT = 2;
    localparam int WIN_LOG2  = 4;
    localparam int WIN_BASE [WIN_COUNT] = '{32'h20, 32'h30};
endpackage

// File: rtl/nvp_gate.sv
// Access gate: decides whether one byte address may be touched, given the
// lock bits. Assumes windows are aligned to 2**WIN_LOG2 bytes.
module nvp_gate
    import nvp_pkg::*;
#(
    parameter int MEM_BYTES = 1024,
    parameter int AW        = 16
) (
    input  logic [AW-1:0]        addr,
    input  logic [WIN_COUNT-1:0] lock,
    output logic                 ok
);
    localparam logic [AW:0] LIMIT = (AW+1)'(MEM_BYTES);
    localparam int          TW    = AW - WIN_LOG2;

    logic [WIN_COUNT-1:0] hit;

    // One comparator per window on the address bits above the window size.
    for (genvar w = 0; w < WIN_COUNT; w++) begin : g_win
        assign hit[w] = lock[w] && (addr[AW-1:WIN_LOG2] == TW'(WIN_BASE[w] >> WIN_LOG2));
    end

    // The byte is reachable only if it is in range and in no locked window.
    assign ok = ({1'b0, addr} < LIMIT) && !(|hit);
endmodule

// File: rtl/nvp_mem.sv
// Byte store with one write port and RP combinational read ports.
// Contents are not reset; indices are already reduced to IW bits.
module nvp_mem #(
    parameter int DEPTH = 1024,
    parameter int IW    = 10,
    parameter int RP    = 2
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [IW-1:0]        widx,
    input  logic [7:0]           wdata,
    input  logic [RP-1:0][IW-1:0] ridx,
    output logic [RP-1:0][7:0]   rdata
);
    logic [7:0] store [DEPTH];

    // Single write port.
    always_ff @(posedge clk) begin
        if (we) store[widx] <= wdata;
    end

    // Independent read ports, each seeing the contents before this edge.
    for (genvar r = 0; r < RP; r++) begin : g_rd
        assign rdata[r] = store[ridx[r]];
    end
endmodule

// File: rtl/nvp_direct_seq.sv
// Direct transfer sequencer: splits a 1, 2 or 4 byte transfer into one
// byte step per clock, most significant byte at the lowest address.
// Assumes byte_rdata is already gated (0xFF for blocked bytes).
module nvp_direct_seq
    import nvp_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [1:0]    size,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    input  logic [7:0]    byte_rdata,
    output logic [AW-1:0] byte_addr,
    output logic          byte_we,
    output logic [7:0]    byte_wdata,
    output logic          busy,
    output logic          done,
    output logic [31:0]   rdata
);
    logic [AW-1:0] base_q;
    logic [1:0]    idx_q;
    logic [1:0]    last_q;
    logic          we_q;
    logic [31:0]   wdata_q;
    logic [23:0]   acc_q;
    logic [1:0]    last_d;
    logic [1:0]    sel;

    // Translate the size code into the index of the final byte.
    always_comb begin
        case (dsize_e'(size))
            SZ_BYTE: last_d = 2'd0;
            SZ_HALF: last_d = 2'd1;
            default: last_d = 2'd3;
        endcase
    end

    // Address and data of the byte step in progress.
    assign sel        = last_q - idx_q;
    assign byte_addr  = base_q + AW'(idx_q);
    assign byte_wdata = wdata_q[{sel, 3'b000} +: 8];
    assign byte_we    = busy && we_q;

    // Step through the bytes; accept a new request only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            rdata   <= '0;
            idx_q   <= '0;
            last_q  <= '0;
            base_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            acc_q   <= '0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                if (!we_q) acc_q <= {acc_q[15:0], byte_rdata};
                if (idx_q == last_q) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    if (!we_q) rdata <= {acc_q, byte_rdata};
                end else begin
                    idx_q <= idx_q + 2'd1;
                end
            end else if (req) begin
                busy    <= 1'b1;
                idx_q   <= '0;
                last_q  <= last_d;
                base_q  <= addr;
                we_q    <= we;
                wdata_q <= wdata;
                acc_q   <= '0;
            end
        end
    end
endmodule

// File: rtl/nvp_port_top.sv
// Indirect byte store port with two lockable windows and a direct path.
// Assumes MEM_BYTES <= 2**AW. A direct write byte takes the single write
// port ahead of a port data write in the same clock.
module nvp_port_top
    import nvp_pkg::*;
#(
    parameter int MEM_BYTES = 1024,
    parameter int AW        = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    pb_off,
    input  logic          pb_wr,
    input  logic          pb_rd,
    input  logic [7:0]    pb_wdata,
    output logic [7:0]    pb_rdata,
    input  logic          dir_req,
    input  logic          dir_we,
    input  logic [1:0]    dir_size,
    input  logic [AW-1:0] dir_addr,
    input  logic [31:0]   dir_wdata,
    output logic [31:0]   dir_rdata,
    output logic          dir_busy,
    output logic          dir_done,
    input  logic [1:0]    lock_tgl
);
    localparam int IW = $clog2(MEM_BYTES);
    localparam int NP = 2;

    logic [AW-1:0]          addr_q;
    logic [WIN_COUNT-1:0]   lock_q;
    logic [7:0]             rdata_q;
    logic [AW-1:0]          dir_baddr;
    logic                   dir_bwe;
    logic [7:0]             dir_bwdata;
    logic [NP-1:0][AW-1:0]  chk_addr;
    logic [NP-1:0]          chk_ok;
    logic [NP-1:0][IW-1:0]  rd_idx;
    logic [NP-1:0][7:0]     rd_raw;
    logic [7:0]             port_byte;
    logic [7:0]             dir_byte;
    logic                   port_dwr;
    logic                   mem_we;
    logic [AW-1:0]          mem_waddr;
    logic [7:0]             mem_wdata;

    assign chk_addr[0] = addr_q;
    assign chk_addr[1] = dir_baddr;

    // One gate and one read index per access path.
    for (genvar p = 0; p < NP; p++) begin : g_path
        nvp_gate #(.MEM_BYTES(MEM_BYTES), .AW(AW)) u_gate (
            .addr (chk_addr[p]),
            .lock (lock_q),
            .ok   (chk_ok[p])
        );
        assign rd_idx[p] = chk_addr[p][IW-1:0];
    end

    assign port_byte = chk_ok[0] ? rd_raw[0] : 8'hFF;
    assign dir_byte  = chk_ok[1] ? rd_raw[1] : 8'hFF;

    // Write port arbitration: a direct byte wins, a port write is dropped.
    assign port_dwr  = pb_wr && (pb_off == OFF_DATA);
    assign mem_we    = dir_bwe ? chk_ok[1] : (port_dwr && chk_ok[0]);
    assign mem_waddr = dir_bwe ? dir_baddr : addr_q;
    assign mem_wdata = dir_bwe ? dir_bwdata : pb_wdata;

    nvp_mem #(.DEPTH(MEM_BYTES), .IW(IW), .RP(NP)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .widx  (mem_waddr[IW-1:0]),
        .wdata (mem_wdata),
        .ridx  (rd_idx),
        .rdata (rd_raw)
    );

    nvp_direct_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (dir_req),
        .we         (dir_we),
        .size       (dir_size),
        .addr       (dir_addr),
        .wdata      (dir_wdata),
        .byte_rdata (dir_byte),
        .byte_addr  (dir_baddr),
        .byte_we    (dir_bwe),
        .byte_wdata (dir_bwdata),
        .busy       (dir_busy),
        .done       (dir_done),
        .rdata      (dir_rdata)
    );

    // Address latch: byte loads at offsets 0/1, cleared by each data write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (pb_wr) begin
            case (pb_off)
                OFF_ALO:  addr_q[7:0]    <= pb_wdata;
                OFF_AHI:  addr_q[AW-1:8] <= pb_wdata[AW-9:0];
                OFF_DATA: addr_q         <= '0;
                default:  addr_q         <= addr_q;
            endcase
        end
    end

    // Lock bits: each toggle request inverts its own bit.
    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= '0;
        else        lock_q <= lock_q ^ lock_tgl;
    end

    // Port read data register: data offset returns the gated byte.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= 8'hFF;
        else if (pb_rd) rdata_q <= (pb_off == OFF_DATA) ? port_byte : 8'hFF;
    end

    assign pb_rdata = rdata_q;
endmodule

// File: rtl/nvp_port_chk.sv
// Assertion checker for nvp_port_top, attached through bind.
module nvp_port_chk #(
    parameter int MEM_BYTES = 1024,
    parameter int AW        = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    pb_off,
    input logic          pb_wr,
    input logic          pb_rd,
    input logic [7:0]    pb_wdata,
    input logic [7:0]    pb_rdata,
    input logic          dir_busy,
    input logic          dir_done,
    input logic [1:0]    lock_tgl,
    input logic [AW-1:0] addr_q,
    input logic [1:0]    lock_q,
    input logic          mem_we,
    input logic [AW-1:0] mem_waddr
);
    localparam logic [AW:0] LIMIT = (AW+1)'(MEM_BYTES);

    AST_ADDR_LOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_wr && pb_off == 2'd0) |=> (addr_q[7:0] == $past(pb_wdata))); // R1
    AST_LATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_wr && pb_off == 2'd3) |=> (addr_q == '0)); // R2
    AST_OTHER_OFF_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_rd && pb_off != 2'd3) |=> (pb_rdata == 8'hFF)); // R3
    AST_LOCK0_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        lock_tgl[0] |=> (lock_q[0] != $past(lock_q[0]))); // R4
    AST_WIN0_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !(lock_q[0] && mem_waddr >= AW'(32'h20) && mem_waddr <= AW'(32'h2F))); // R5
    AST_WIN1_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !(lock_q[1] && mem_waddr >= AW'(32'h30) && mem_waddr <= AW'(32'h3F))); // R6
    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ({1'b0, mem_waddr} < LIMIT)); // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        dir_done |=> !dir_done); // R9
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dir_busy) |-> dir_done); // R9
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (lock_q == 2'b00 && addr_q == '0 && pb_rdata == 8'hFF)); // R10
endmodule

bind nvp_port_top nvp_port_chk #(.MEM_BYTES(MEM_BYTES), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pb_off    (pb_off),
    .pb_wr     (pb_wr),
    .pb_rd     (pb_rd),
    .pb_wdata  (pb_wdata),
    .pb_rdata  (pb_rdata),
    .dir_busy  (dir_busy),
    .dir_done  (dir_done),
    .lock_tgl  (lock_tgl),
    .addr_q    (addr_q),
    .lock_q    (lock_q),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr)
);

// File: tb/nvp_port_top_tb_top.sv
// Bench: a behavioural per-clock model is compared with the outputs every
// cycle, plus directed checks with literal expected values.
module nvp_port_top_tb_top;
    localparam int MEMB = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pb_off = '0;
    logic        pb_wr = 1'b0;
    logic        pb_rd = 1'b0;
    logic [7:0]  pb_wdata = '0;
    logic [7:0]  pb_rdata;
    logic        dir_req = 1'b0;
    logic        dir_we = 1'b0;
    logic [1:0]  dir_size = '0;
    logic [15:0] dir_addr = '0;
    logic [31:0] dir_wdata = '0;
    logic [31:0] dir_rdata;
    logic        dir_busy;
    logic        dir_done;
    logic [1:0]  lock_tgl = '0;

    int    n_tests = 0;
    int    n_fail = 0;
    string cur_req = "R10";
    bit    started = 1'b0;

    always #5 clk = ~clk;

    nvp_port_top dut_i (
        .clk(clk), .rst_n(rst_n), .pb_off(pb_off), .pb_wr(pb_wr), .pb_rd(pb_rd),
        .pb_wdata(pb_wdata), .pb_rdata(pb_rdata), .dir_req(dir_req), .dir_we(dir_we),
        .dir_size(dir_size), .dir_addr(dir_addr), .dir_wdata(dir_wdata),
        .dir_rdata(dir_rdata), .dir_busy(dir_busy), .dir_done(dir_done),
        .lock_tgl(lock_tgl)
    );

    // ---------------- reference model ----------------
    logic [7:0]  m_mem [int];
    int          m_addr = 0;
    bit [1:0]    m_lock = 0;
    bit [7:0]    m_prd = 8'hFF;
    bit          m_busy = 0, m_done = 0, m_we = 0;
    bit [31:0]   m_drd = 0, m_wq = 0, m_acc = 0;
    int          m_base = 0, m_idx = 0, m_n = 1;

    function automatic bit m_ok(int a, bit [1:0] lk);
        if (a >= MEMB) return 0;
        if (lk[0] && a >= 'h20 && a <= 'h2F) return 0;
        if (lk[1] && a >= 'h30 && a <= 'h3F) return 0;
        return 1;
    endfunction

    function automatic bit [7:0] m_rd(int a, bit [1:0] lk);
        if (!m_ok(a, lk)) return 8'hFF;
        if (m_mem.exists(a)) return m_mem[a];
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_addr = 0; m_lock = 0; m_prd = 8'hFF;
            m_busy = 0; m_done = 0; m_drd = 0;
        end else begin
            int       pa;
            bit [1:0] lk;
            bit       dw;
            int       dwa;
            bit [7:0] dwd;
            pa = m_addr; lk = m_lock; dw = 0; dwa = 0; dwd = 0;
            m_done = 0;
            if (m_busy) begin
                int a;
                a = (m_base + m_idx) & 'hFFFF;
                if (m_we) begin
                    dw = 1; dwa = a; dwd = m_wq[8*(m_n-1-m_idx) +: 8];
                end else begin
                    m_acc = (m_acc << 8) | 32'(m_rd(a, lk));
                end
                if (m_idx == m_n - 1) begin
                    m_busy = 0; m_done = 1;
                    if (!m_we) m_drd = m_acc;
                end else begin
                    m_idx++;
                end
            end else if (dir_req) begin
                m_busy = 1; m_idx = 0; m_base = int'(dir_addr); m_we = dir_we;
                m_wq = dir_wdata; m_acc = 0;
                m_n = (dir_size == 0) ? 1 : (dir_size == 1) ? 2 : 4;
            end
            if (pb_rd) m_prd = (pb_off == 3) ? m_rd(pa, lk) : 8'hFF;
            if (dw && m_ok(dwa, lk)) m_mem[dwa] = dwd;
            if (pb_wr) begin
                case (pb_off)
                    2'd0: m_addr = (m_addr & 'hFF00) | int'(pb_wdata);
                    2'd1: m_addr = (m_addr & 'h00FF) | (int'(pb_wdata) << 8);
                    2'd3: begin
                        if (!dw && m_ok(pa, lk)) m_mem[pa] = pb_wdata;
                        m_addr = 0;
                    end
                    default: ;
                endcase
            end
            m_lock = m_lock ^ lock_tgl;
        end
    end

    task automatic check(input bit [31:0] act, input bit [31:0] exp, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            check(32'(pb_rdata), 32'(m_prd), "pb_rdata vs model");
            check(32'(dir_busy), 32'(m_busy), "dir_busy vs model");
            check(32'(dir_done), 32'(m_done), "dir_done vs model");
            check(dir_rdata, m_drd, "dir_rdata vs model");
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic pwr(input bit [1:0] off, input bit [7:0] d);
        pb_off = off; pb_wdata = d; pb_wr = 1'b1;
        @(negedge clk);
        pb_wr = 1'b0;
    endtask

    task automatic set_addr(input bit [15:0] a);
        pwr(2'd0, a[7:0]);
        pwr(2'd1, a[15:8]);
    endtask

    task automatic prd(input bit [1:0] off);
        pb_off = off; pb_rd = 1'b1;
        @(negedge clk);
        pb_rd = 1'b0;
    endtask

    task automatic tgl(input int i);
        lock_tgl[i] = 1'b1;
        @(negedge clk);
        lock_tgl = '0;
    endtask

    task automatic dxfer(input bit we, input bit [1:0] sz, input bit [15:0] a,
                         input bit [31:0] d, output int busy_cycles);
        dir_req = 1'b1; dir_we = we; dir_size = sz; dir_addr = a; dir_wdata = d;
        @(negedge clk);
        dir_req = 1'b0;
        busy_cycles = 0;
        while (!dir_done) begin
            if (dir_busy) busy_cycles++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int bc;
        repeat (3) @(negedge clk);
        started = 1'b1;
        cur_req = "R10";
        check(32'(pb_rdata), 32'hFF, "reset read data");
        check(32'(dir_busy), 0, "reset busy");
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2: fill low region through the port
        cur_req = "R1";
        for (int i = 0; i < 'h50; i++) begin
            set_addr(16'(i));
            pwr(2'd3, 8'(i) ^ 8'h5A);
        end
        cur_req = "R3";
        set_addr(16'h0013); prd(2'd3);
        check(32'(pb_rdata), 32'h49, "readback 0x13");
        set_addr(16'h004F); prd(2'd3);
        check(32'(pb_rdata), 32'h15, "readback 0x4F");
        prd(2'd3);
        check(32'(pb_rdata), 32'h15, "read keeps address");
        prd(2'd0); check(32'(pb_rdata), 32'hFF, "offset 0 read");
        prd(2'd1); check(32'(pb_rdata), 32'hFF, "offset 1 read");
        prd(2'd2); check(32'(pb_rdata), 32'hFF, "offset 2 read");

        // R2: second data write lands at address 0
        cur_req = "R2";
        set_addr(16'h0015); pwr(2'd3, 8'h11); pwr(2'd3, 8'h22);
        prd(2'd3); check(32'(pb_rdata), 32'h22, "latch cleared after write");
        set_addr(16'h0015); prd(2'd3); check(32'(pb_rdata), 32'h11, "first write stored");

        // R4 R5: lock window 0
        cur_req = "R5";
        tgl(0);
        set_addr(16'h0025); prd(2'd3); check(32'(pb_rdata), 32'hFF, "locked read 0x25");
        pwr(2'd3, 8'h99);
        set_addr(16'h0030); prd(2'd3); check(32'(pb_rdata), 32'h6A, "0x30 open under lock0");
        cur_req = "R4";
        tgl(0);
        set_addr(16'h0025); prd(2'd3); check(32'(pb_rdata), 32'h7F, "unlock keeps old 0x25");

        // R6: lock window 1
        cur_req = "R6";
        tgl(1);
        set_addr(16'h003F); prd(2'd3); check(32'(pb_rdata), 32'hFF, "locked read 0x3F");
        pwr(2'd3, 8'h00);
        set_addr(16'h002F); prd(2'd3); check(32'(pb_rdata), 32'h75, "0x2F open under lock1");
        tgl(1);
        set_addr(16'h003F); prd(2'd3); check(32'(pb_rdata), 32'h65, "0x3F kept");

        // R7: out of range
        cur_req = "R7";
        set_addr(16'(MEMB)); pwr(2'd3, 8'hAB);
        set_addr(16'(MEMB)); prd(2'd3); check(32'(pb_rdata), 32'hFF, "read at size");
        set_addr(16'hFFFF); prd(2'd3); check(32'(pb_rdata), 32'hFF, "read at 0xFFFF");

        // R8 R9: direct transfers
        cur_req = "R9";
        dxfer(1'b1, 2'd2, 16'h0100, 32'hA1B2C3D4, bc);
        check(32'(bc), 4, "word busy cycles");
        cur_req = "R8";
        set_addr(16'h0100); prd(2'd3); check(32'(pb_rdata), 32'hA1, "MSB at lowest");
        set_addr(16'h0103); prd(2'd3); check(32'(pb_rdata), 32'hD4, "LSB at highest");
        dxfer(1'b0, 2'd2, 16'h0100, 32'h0, bc);
        check(dir_rdata, 32'hA1B2C3D4, "word read");
        dxfer(1'b0, 2'd1, 16'h0102, 32'h0, bc);
        check(dir_rdata, 32'h0000C3D4, "half read");
        cur_req = "R9";
        check(32'(bc), 2, "half busy cycles");
        cur_req = "R8";
        dxfer(1'b0, 2'd0, 16'h0101, 32'h0, bc);
        check(dir_rdata, 32'h000000B2, "byte read");
        dxfer(1'b1, 2'd1, 16'h0104, 32'h0000BEEF, bc);
        set_addr(16'h0105); prd(2'd3); check(32'(pb_rdata), 32'hEF, "half write low byte");
        dxfer(1'b0, 2'd3, 16'h0102, 32'h0, bc);
        check(dir_rdata, 32'hC3D4BEEF, "size 3 as word");

        // R5 via direct path straddling both windows
        cur_req = "R5";
        tgl(0);
        dxfer(1'b1, 2'd2, 16'h002E, 32'h01020304, bc);
        dxfer(1'b0, 2'd2, 16'h002E, 32'h0, bc);
        check(dir_rdata, 32'hFFFF0304, "direct read across lock0");
        tgl(0);
        dxfer(1'b0, 2'd1, 16'h002E, 32'h0, bc);
        check(dir_rdata, 32'h00007475, "lock0 bytes untouched");

        // R11 R9: collision and request during busy
        cur_req = "R11";
        set_addr(16'h0040);
        dir_req = 1'b1; dir_we = 1'b1; dir_size = 2'd2; dir_addr = 16'h0044;
        dir_wdata = 32'h55667788;
        @(negedge clk);
        dir_addr = 16'h0048;
        pb_off = 2'd3; pb_wdata = 8'h77; pb_wr = 1'b1;
        @(negedge clk);
        dir_req = 1'b0; pb_wr = 1'b0;
        while (!dir_done) @(negedge clk);
        set_addr(16'h0040); prd(2'd3); check(32'(pb_rdata), 32'h1A, "port write dropped");
        cur_req = "R9";
        set_addr(16'h0048); prd(2'd3); check(32'(pb_rdata), 32'h12, "busy request ignored");

        // R10: reset keeps store, clears lock and latch
        cur_req = "R10";
        tgl(0);
        set_addr(16'h0025);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check(32'(pb_rdata), 32'hFF, "read data after reset");
        prd(2'd3); check(32'(pb_rdata), 32'h22, "latch zero, store kept");
        set_addr(16'h0025); prd(2'd3); check(32'(pb_rdata), 32'h7F, "lock cleared");

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule